// File: doc/BRIEF.md
# Nonvolatile Transfer Sequencer

This block orders the movement of data between a volatile SRAM array and its nonvolatile shadow cells. It watches two digital supply flags from an analog monitor. One says the supply has sagged to or below the reset level. The other says the supply has climbed past the switch threshold. Whenever the supply drops low, the block latches a pending-recall flag. When the supply comes back above the switch threshold with that flag set, the block starts a recall on its own. Other blocks may also request a store or a recall with one-cycle pulses.

Every transfer runs as two ordered phases, each shown on its own strobe. A store first erases the old nonvolatile contents and then programs the new contents. A recall first clears the SRAM and then copies the nonvolatile data into it. A recall leaves the nonvolatile cells untouched, so it can be repeated any number of times. While any phase runs, the SRAM interface is held off through an I/O-disable output. A one-cycle completion pulse marks the end of each transfer. All phase lengths are parameters counted in clock cycles.

Top module: `nvxfer_seq`

## Requirements
- R1: Reset leaves the pending-recall flag set and all strobes, `io_off_o` and `done_o` low. No transfer starts until `vcc_ok_i` is high and `vcc_low_i` is low.
- R2: The pending-recall flag is set in every cycle that `vcc_low_i` is high. It is cleared only when a supply-triggered recall completes. While the flag is set, stores are refused; once it is cleared, they are accepted.
- R3: In the first idle cycle with the flag set, `vcc_ok_i` high and `vcc_low_i` low, a recall starts without any request. `clear_o` is high for HW_CLEAR_CYC cycles, and then `copy_o` is high for HW_RECALL_CYC minus HW_CLEAR_CYC cycles.
- R4: An accepted `store_req_i` drives `erase_o` high for ERASE_CYC cycles, and then `program_o` high for PROG_CYC cycles, starting the cycle after the request.
- R5: An accepted `recall_req_i` drives `clear_o` for SW_CLEAR_CYC cycles, and then `copy_o` for the rest of SW_RECALL_CYC cycles. The default of 5000 cycles is 20 µs at 250 MHz.
- R6: At most one phase strobe is high at a time. `io_off_o` is high exactly while a phase strobe is high.
- R7: `done_o` is high for exactly one cycle, in the cycle right after the last phase cycle of a completed transfer.
- R8: `store_req_i` and `recall_req_i` that arrive while a transfer is active are ignored.
- R9: Requests are ignored while the pending flag is set or the supply is not above the switch threshold. When a supply-triggered recall and a store request become eligible in the same cycle, the recall wins.
- R10: `vcc_low_i` during a transfer aborts it. All strobes and `io_off_o` drop in the next cycle, and no `done_o` is given.
- R11: When store and recall requests arrive in the same idle cycle, the store is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| vcc_low_i | input | 1 | Supply at or below the reset level |
| vcc_ok_i | input | 1 | Supply above the switch threshold |
| store_req_i | input | 1 | One-cycle store request |
| recall_req_i | input | 1 | One-cycle recall request |
| erase_o | output | 1 | Store phase 1: erase nonvolatile cells |
| program_o | output | 1 | Store phase 2: program nonvolatile cells |
| clear_o | output | 1 | Recall phase 1: clear SRAM |
| copy_o | output | 1 | Recall phase 2: copy nonvolatile data into SRAM |
| io_off_o | output | 1 | SRAM reads and writes disabled |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The bench counts the cycles of each strobe so that a phase one cycle long or short shows up as a count mismatch. The bench also checks phase order, so a design that ran program before erase, or copy before clear, is reported. Requests are fired in the middle of a running store; a design that restarted or chained a second transfer would show extra strobe cycles or a second completion pulse. The bench also raises a store request in the same cycle the supply recovers. A design that gave the store priority would erase the nonvolatile cells before the SRAM had been restored. Finally, the bench drops the supply in mid-store. A design that kept running, or pulsed `done_o`, after the brownout would be caught, and so would one that failed to recall once the supply returned.

// File: rtl/nvx_pkg.sv
package nvx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ERASE = 3'd1,
    PH_PROG  = 3'd2,
    PH_CLEAR = 3'd3,
    PH_COPY  = 3'd4
  } phase_t;

  function automatic int nvx_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Length of the copy phase given the recall total and its clear part.
  function automatic int nvx_copy_len(input int total, input int clr);
    return total - clr;
  endfunction

endpackage

// File: rtl/nvx_pend_flag.sv
module nvx_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b1;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/nvx_phase_timer.sv
module nvx_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clr_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/nvx_seq_ctrl.sv
module nvx_seq_ctrl
  import nvx_pkg::*;
#(
  parameter int ERASE_CYC     = 8,
  parameter int PROG_CYC      = 8,
  parameter int SW_CLEAR_CYC  = 500,
  parameter int SW_RECALL_CYC = 5000,
  parameter int HW_CLEAR_CYC  = 500,
  parameter int HW_RECALL_CYC = 5000,
  parameter int W             = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort_i,
  input  logic         hw_go_i,
  input  logic         store_go_i,
  input  logic         recall_go_i,
  input  logic         last_i,
  output phase_t       phase_o,
  output logic         load_o,
  output logic [W-1:0] load_val_o,
  output logic         cycle_end_o,
  output logic         hw_end_o
);
  localparam int SW_COPY_CYC = nvx_copy_len(SW_RECALL_CYC, SW_CLEAR_CYC);
  localparam int HW_COPY_CYC = nvx_copy_len(HW_RECALL_CYC, HW_CLEAR_CYC);

  localparam logic [W-1:0] LV_ERASE  = W'(ERASE_CYC - 1);
  localparam logic [W-1:0] LV_PROG   = W'(PROG_CYC - 1);
  localparam logic [W-1:0] LV_SWCLR  = W'(SW_CLEAR_CYC - 1);
  localparam logic [W-1:0] LV_SWCOPY = W'(SW_COPY_CYC - 1);
  localparam logic [W-1:0] LV_HWCLR  = W'(HW_CLEAR_CYC - 1);
  localparam logic [W-1:0] LV_HWCOPY = W'(HW_COPY_CYC - 1);

  phase_t state_q, state_d;
  logic   kind_hw_q;

  always_comb begin
    state_d     = state_q;
    load_o      = 1'b0;
    load_val_o  = '0;
    cycle_end_o = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (hw_go_i) begin
          state_d = PH_CLEAR; load_o = 1'b1; load_val_o = LV_HWCLR;
        end else if (store_go_i) begin
          state_d = PH_ERASE; load_o = 1'b1; load_val_o = LV_ERASE;
        end else if (recall_go_i) begin
          state_d = PH_CLEAR; load_o = 1'b1; load_val_o = LV_SWCLR;
        end
      end
      PH_ERASE: if (last_i) begin
        state_d = PH_PROG; load_o = 1'b1; load_val_o = LV_PROG;
      end
      PH_PROG: if (last_i) begin
        state_d = PH_IDLE; cycle_end_o = 1'b1;
      end
      PH_CLEAR: if (last_i) begin
        state_d = PH_COPY; load_o = 1'b1;
        load_val_o = kind_hw_q ? LV_HWCOPY : LV_SWCOPY;
      end
      PH_COPY: if (last_i) begin
        state_d = PH_IDLE; cycle_end_o = 1'b1;
      end
      default: state_d = PH_IDLE;
    endcase
    if (abort_i) begin
      state_d     = PH_IDLE;
      load_o      = 1'b0;
      cycle_end_o = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PH_IDLE;
      kind_hw_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == PH_IDLE) kind_hw_q <= hw_go_i;
    end
  end

  assign phase_o  = state_q;
  assign hw_end_o = cycle_end_o && kind_hw_q && (state_q == PH_COPY);
endmodule

// File: rtl/nvxfer_seq.sv
module nvxfer_seq
  import nvx_pkg::*;
#(
  parameter int ERASE_CYC     = 8,
  parameter int PROG_CYC      = 8,
  parameter int SW_CLEAR_CYC  = 500,
  parameter int SW_RECALL_CYC = 5000,
  parameter int HW_CLEAR_CYC  = 500,
  parameter int HW_RECALL_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_low_i,
  input  logic vcc_ok_i,
  input  logic store_req_i,
  input  logic recall_req_i,
  output logic erase_o,
  output logic program_o,
  output logic clear_o,
  output logic copy_o,
  output logic io_off_o,
  output logic done_o
);
  localparam int MAX_CYC = nvx_max(nvx_max(ERASE_CYC, PROG_CYC),
                                   nvx_max(SW_RECALL_CYC, HW_RECALL_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  phase_t           phase;
  logic             pend_flag, idle, supply_ok;
  logic             hw_go, store_go, recall_go;
  logic             tmr_load, tmr_last, cycle_end, hw_end;
  logic [CNT_W-1:0] tmr_val;
  logic             done_q;

  assign idle      = (phase == PH_IDLE);
  assign supply_ok = vcc_ok_i && !vcc_low_i;
  assign hw_go     = idle && supply_ok && pend_flag;
  assign store_go  = idle && supply_ok && !pend_flag && store_req_i;
  assign recall_go = idle && supply_ok && !pend_flag && recall_req_i;

  nvx_pend_flag u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (vcc_low_i),
    .clr_i  (hw_end),
    .flag_o (pend_flag)
  );

  nvx_phase_timer #(.W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .clr_i      (vcc_low_i),
    .last_o     (tmr_last)
  );

  nvx_seq_ctrl #(
    .ERASE_CYC     (ERASE_CYC),
    .PROG_CYC      (PROG_CYC),
    .SW_CLEAR_CYC  (SW_CLEAR_CYC),
    .SW_RECALL_CYC (SW_RECALL_CYC),
    .HW_CLEAR_CYC  (HW_CLEAR_CYC),
    .HW_RECALL_CYC (HW_RECALL_CYC),
    .W             (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .abort_i     (vcc_low_i),
    .hw_go_i     (hw_go),
    .store_go_i  (store_go),
    .recall_go_i (recall_go),
    .last_i      (tmr_last),
    .phase_o     (phase),
    .load_o      (tmr_load),
    .load_val_o  (tmr_val),
    .cycle_end_o (cycle_end),
    .hw_end_o    (hw_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= cycle_end;
  end

  assign erase_o   = (phase == PH_ERASE);
  assign program_o = (phase == PH_PROG);
  assign clear_o   = (phase == PH_CLEAR);
  assign copy_o    = (phase == PH_COPY);
  assign io_off_o  = !idle;
  assign done_o    = done_q;
endmodule

// File: rtl/nvx_chk.sv
module nvx_chk (
  input logic clk,
  input logic rst_n,
  input logic vcc_low_i,
  input logic vcc_ok_i,
  input logic erase_o,
  input logic program_o,
  input logic clear_o,
  input logic copy_o,
  input logic io_off_o,
  input logic done_o,
  input logic pend_flag,
  input logic hw_go,
  input logic hw_end
);
  // R6
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_o, program_o, clear_o, copy_o}));

  // R6
  io_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_o || program_o || clear_o || copy_o) |-> io_off_o);

  // R4
  store_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(program_o) |-> $past(erase_o));

  // R3
  recall_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clear_o) && !$past(vcc_low_i)) |-> copy_o);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !io_off_o);

  // R10
  brownout_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_low_i |=> (!io_off_o && pend_flag && !done_o));

  // R3
  hw_start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_go |-> (vcc_ok_i && pend_flag && !vcc_low_i));

  // R2
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_end |=> !pend_flag);
endmodule

bind nvxfer_seq nvx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vcc_low_i (vcc_low_i),
  .vcc_ok_i  (vcc_ok_i),
  .erase_o   (erase_o),
  .program_o (program_o),
  .clear_o   (clear_o),
  .copy_o    (copy_o),
  .io_off_o  (io_off_o),
  .done_o    (done_o),
  .pend_flag (pend_flag),
  .hw_go     (hw_go),
  .hw_end    (hw_end)
);

// File: tb/sim_nvxfer_seq.sv
module sim_nvxfer_seq;
  localparam int E_C = 4, P_C = 6, SC_C = 3, SR_C = 8, HC_C = 5, HR_C = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vcc_low = 1'b1, vcc_ok = 1'b0, st_req = 1'b0, rc_req = 1'b0;
  logic erase, prog, clr, cpy, io_off, done;

  always #2 clk = ~clk;  // 250 MHz

  nvxfer_seq #(
    .ERASE_CYC(E_C), .PROG_CYC(P_C), .SW_CLEAR_CYC(SC_C),
    .SW_RECALL_CYC(SR_C), .HW_CLEAR_CYC(HC_C), .HW_RECALL_CYC(HR_C)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .vcc_low_i(vcc_low), .vcc_ok_i(vcc_ok),
    .store_req_i(st_req), .recall_req_i(rc_req),
    .erase_o(erase), .program_o(prog), .clear_o(clr), .copy_o(cpy),
    .io_off_o(io_off), .done_o(done)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  int e_n, p_n, c_n, y_n, io_n, d_n, d_at, ord_err;

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // kind 0: none, 1: fire both requests at sample inj, 2: supply drop at inj
  task automatic observe(input int len, input int kind, input int inj);
    e_n = 0; p_n = 0; c_n = 0; y_n = 0; io_n = 0; d_n = 0; d_at = -1; ord_err = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) begin st_req = 1'b0; rc_req = 1'b0; end
      if (prog && e_n == 0) ord_err++;
      if (erase && p_n > 0) ord_err++;
      if (cpy && c_n == 0) ord_err++;
      if (clr && y_n > 0) ord_err++;
      if ((int'(erase) + int'(prog) + int'(clr) + int'(cpy)) > 1) ord_err++;
      if (io_off != (erase | prog | clr | cpy)) ord_err++;
      e_n += int'(erase); p_n += int'(prog); c_n += int'(clr); y_n += int'(cpy);
      io_n += int'(io_off);
      if (done) begin d_n++; if (d_at < 0) d_at = i; end
      if (kind == 1 && i == inj) begin st_req = 1'b1; rc_req = 1'b1; end
      if (kind == 1 && i == inj + 1) begin st_req = 1'b0; rc_req = 1'b0; end
      if (kind == 2 && i == inj) begin vcc_low = 1'b1; vcc_ok = 1'b0; end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(int'(erase | prog | clr | cpy), 0, "R1 strobes in reset");
    chk(int'(io_off | done), 0, "R1 io_off/done in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    vcc_low = 1'b0;
    st_req = 1'b1;
    observe(20, 0, 0);
    chk(io_n, 0, "R1 no transfer while supply below switch");
  endtask

  task automatic t_hw_recall();
    @(negedge clk); vcc_ok = 1'b1; st_req = 1'b1;
    observe(25, 0, 0);
    chk(c_n, HC_C, "R3 hw clear length");
    chk(y_n, HR_C - HC_C, "R3 hw copy length");
    chk(e_n, 0, "R9 recall beats store on power-up");
    chk(ord_err, 0, "R6 order/exclusive/io_off");
    chk(d_at, HR_C, "R7 done timing after hw recall");
    chk(d_n, 1, "R7 single done");
  endtask

  task automatic t_store();
    @(negedge clk); st_req = 1'b1;
    observe(20, 0, 0);
    chk(e_n, E_C, "R4 erase length");
    chk(p_n, P_C, "R4 program length");
    chk(io_n, E_C + P_C, "R6 io_off span store");
    chk(d_at, E_C + P_C, "R7 done timing after store");
    chk(ord_err, 0, "R4 store order");
    chk(int'(e_n > 0), 1, "R2 pending cleared by hw recall");
  endtask

  task automatic t_sw_recall();
    @(negedge clk); rc_req = 1'b1;
    observe(20, 0, 0);
    chk(c_n, SC_C, "R5 sw clear length");
    chk(y_n, SR_C - SC_C, "R5 sw copy length");
    chk(d_at, SR_C, "R7 done timing after sw recall");
    chk(ord_err, 0, "R5 recall order");
  endtask

  task automatic t_busy_ignore();
    @(negedge clk); st_req = 1'b1;
    observe(30, 1, 3);
    chk(e_n, E_C, "R8 erase unchanged");
    chk(p_n, P_C, "R8 program unchanged");
    chk(c_n + y_n, 0, "R8 no recall chained");
    chk(d_n, 1, "R8 one done");
  endtask

  task automatic t_both_idle();
    @(negedge clk); st_req = 1'b1; rc_req = 1'b1;
    observe(20, 0, 0);
    chk(e_n, E_C, "R11 store taken");
    chk(c_n + y_n, 0, "R11 recall dropped");
  endtask

  task automatic t_brownout();
    @(negedge clk); st_req = 1'b1;
    observe(20, 2, 2);
    chk(io_n, 3, "R10 abort stops io_off");
    chk(d_n, 0, "R10 no done on abort");
    @(negedge clk); vcc_low = 1'b0;
    @(negedge clk); st_req = 1'b1; rc_req = 1'b1;
    observe(10, 0, 0);
    chk(io_n, 0, "R9 requests ignored supply not ok");
    @(negedge clk); vcc_ok = 1'b1; st_req = 1'b1;
    observe(25, 0, 0);
    chk(c_n, HC_C, "R2 pending set by brownout, recall runs");
    chk(e_n, 0, "R9 recall wins over store");
    chk(d_n, 1, "R7 done after post-brownout recall");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hw_recall();
    t_store();
    t_sw_recall();
    t_busy_ignore();
    t_both_idle();
    t_brownout();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule